// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block links two open-drain segments of one I2C line, called side A and side B. One instance serves SDA and a second, independent instance serves SCL. It reads the sampled level of each side and produces one pull-down enable per side. Each enable is meant for a pad that drives zero when enabled and floats otherwise. When an external device pulls one side low, the repeater pulls the other side low too.

The repeater must not latch the line low through its own drive. To prevent this, an owner register records which side went low first. The repeater then ignores the level of the side it is driving, because that side reads low only due to its own pull. The driven side is released when the owning side rises.

After a release, the formerly driven side gets a settle window to rise before a low on it can claim ownership. A side that is still held low by an external device after the window is then treated as a new low. This is how clock stretching and acknowledge hand over from one side to the other.

A connect input from a hot-plug controller gates all driving. While connect is low, the two segments are fully isolated.

Top module: `i2c_line_repeater`

## Requirements
- R1: With connect high and no owner, a low sampled on side A (not blocked by a settle window) makes `b_pull_o` go high after SYNC_STAGES+1 rising clock edges, while `a_pull_o` stays low.
- R2: With connect high and no owner, a low sampled on side B (not blocked, and with side A high or blocked) makes `a_pull_o` go high after SYNC_STAGES+1 rising clock edges, while `b_pull_o` stays low.
- R3: While the owning side is sampled low, the other side stays pulled. This holds whether or not an external device on the driven side pulls it low or lets it go.
- R4: One edge after the owning side is sampled high, both enables are low and the owner is cleared. There is no re-drive until a new low event occurs.
- R5: While `connect_i` is low, both enables are low in the same cycle and the owner is cleared. After `connect_i` returns high, a side that is still low claims ownership afresh at the next edge.
- R6: If both sides are sampled low in the same cycle with no owner and no settle block, side A becomes owner, so `b_pull_o` goes high and `a_pull_o` stays low.
- R7: After a release, a low sampled on the formerly driven side is ignored for SETTLE_CYCLES edges. A low still present after that window claims ownership for that side.
- R8: `a_pull_o` and `b_pull_o` are never high at the same time. A high enable means "drive zero", and the block never drives a one.
- R9: During and right after reset both enables are low, and the sampled levels reset to the idle-high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_i | input | 1 | High allows the segments to be joined |
| a_line_i | input | 1 | Level read from side A (1 = released) |
| b_line_i | input | 1 | Level read from side B (1 = released) |
| a_pull_o | output | 1 | High enables the pull-down on side A |
| b_pull_o | output | 1 | High enables the pull-down on side B |

## Verification
The bench targets a handover where the owning side releases while the far side is still held low externally. A design that never blocked its own driven side would latch low forever. A design without the settle window would bounce ownership back on its own stale sample. It also drives simultaneous falls, where a wrong tie rule would drive both pads. It drops connect during an active transfer, where a design that kept its owner would glitch the line after reconnect. Random wired-AND traffic on both sides is compared every cycle against a bench model of the ownership rules.

// File: rtl/i2crep_pkg.sv
package i2crep_pkg;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_A    = 2'd1,
      OWN_B    = 2'd2
   } owner_e;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

endpackage

// File: rtl/i2crep_sync.sv
module i2crep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("i2crep_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else if (STAGES == 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_q <= 1'b1;
         else        q_q <= d_i;
      end
      assign q_o = q_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/i2crep_settle.sv
module i2crep_settle #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic load_i,
   output logic busy_o
);

   localparam int CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("i2crep_settle: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear_i)        cnt_q <= '0;
      else if (load_i)         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R7: a load opens the settle window on the following cycle
   p_settle_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clear_i) |=> busy_o);

   // R5: a clear closes the window
   p_settle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !busy_o);

endmodule

// File: rtl/i2crep_owner.sv
module i2crep_owner
   import i2crep_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   connect_i,
   input  logic   a_s_i,
   input  logic   b_s_i,
   input  logic   busy_i,
   output logic   load_o,
   output logic   clear_o,
   output owner_e owner_o
);

   owner_e own_q, own_d;
   side_e  blk_q, blk_d;
   logic   a_blk, b_blk;

   assign a_blk = busy_i && (blk_q == SIDE_A);
   assign b_blk = busy_i && (blk_q == SIDE_B);

   always_comb begin
      own_d  = own_q;
      blk_d  = blk_q;
      load_o = 1'b0;
      if (!connect_i) begin
         own_d = OWN_NONE;
      end else begin
         case (own_q)
            OWN_NONE: begin
               if (!a_s_i && !a_blk)      own_d = OWN_A;
               else if (!b_s_i && !b_blk) own_d = OWN_B;
            end
            OWN_A: begin
               if (a_s_i) begin
                  own_d  = OWN_NONE;
                  blk_d  = SIDE_B;
                  load_o = 1'b1;
               end
            end
            OWN_B: begin
               if (b_s_i) begin
                  own_d  = OWN_NONE;
                  blk_d  = SIDE_A;
                  load_o = 1'b1;
               end
            end
            default: own_d = OWN_NONE;
         endcase
      end
   end

   assign clear_o = !connect_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= OWN_NONE;
         blk_q <= SIDE_A;
      end else begin
         own_q <= own_d;
         blk_q <= blk_d;
      end
   end

   assign owner_o = own_q;

   // R1: unblocked low on A with no owner claims A
   p_claim_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && connect_i && !a_s_i && !a_blk) |=> (own_q == OWN_A));

   // R2: unblocked low on B, A idle or blocked, claims B
   p_claim_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && connect_i && (a_s_i || a_blk) && !b_s_i && !b_blk)
      |=> (own_q == OWN_B));

   // R3: owner held while its side stays low
   p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_A && connect_i && !a_s_i) |=> (own_q == OWN_A));

   // R4: release of owning side clears owner and opens settle window
   p_release_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_A && connect_i && a_s_i) |=> (own_q == OWN_NONE && busy_i));

   // R5: disconnect clears owner
   p_disc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !connect_i |=> (own_q == OWN_NONE));

   // R6: simultaneous lows resolve to A
   p_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && connect_i && !a_s_i && !b_s_i && !a_blk && !b_blk)
      |=> (own_q == OWN_A));

   // R7: blocked side cannot claim during the window
   p_block_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && connect_i && b_blk && a_s_i) |=> (own_q == OWN_NONE));

endmodule

// File: rtl/i2c_line_repeater.sv
module i2c_line_repeater
   import i2crep_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic connect_i,
   input  logic a_line_i,
   input  logic b_line_i,
   output logic a_pull_o,
   output logic b_pull_o
);

   localparam int NSIDES = 2;

   if (SETTLE_CYCLES < SYNC_STAGES || SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("i2c_line_repeater: SETTLE_CYCLES must cover SYNC_STAGES and be at least 1");
   end

   logic [NSIDES-1:0] line_raw;
   logic [NSIDES-1:0] line_s;
   logic              busy, load, clear;
   owner_e            owner;

   assign line_raw = {b_line_i, a_line_i};

   for (genvar i = 0; i < NSIDES; i++) begin : g_side
      i2crep_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (line_raw[i]),
         .q_o   (line_s[i])
      );
   end

   i2crep_owner u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .connect_i (connect_i),
      .a_s_i     (line_s[0]),
      .b_s_i     (line_s[1]),
      .busy_i    (busy),
      .load_o    (load),
      .clear_o   (clear),
      .owner_o   (owner)
   );

   i2crep_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .load_i  (load),
      .busy_o  (busy)
   );

   assign a_pull_o = connect_i && (owner == OWN_B);
   assign b_pull_o = connect_i && (owner == OWN_A);

   // R8: never both pads driven
   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_pull_o, b_pull_o}));

endmodule

// File: tb/i2c_line_repeater_bench.sv
module i2c_line_repeater_bench;

   localparam int CLK_PERIOD = 10;
   localparam int S = 2;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic connect = 1'b1;
   logic ext_a = 1'b0, ext_b = 1'b0;
   logic nx_a = 1'b0, nx_b = 1'b0, nx_conn = 1'b1, nx_rst = 1'b0;
   logic a_pull, b_pull;
   wire  a_line = ~(ext_a | a_pull);
   wire  b_line = ~(ext_b | b_pull);
   logic samp_a, samp_b;

   int n_chk = 0;
   int n_err = 0;

   // model state: 0 none, 1 A owns, 2 B owns; blk 0 = A blocked, 1 = B blocked
   int         m_own = 0;
   int         m_cnt = 0;
   int         m_blk = 0;
   logic [S-1:0] m_pa = '1, m_pb = '1;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_line_repeater #(.SYNC_STAGES(S), .SETTLE_CYCLES(SETTLE)) u_i2c_line_repeater (
      .clk       (clk),
      .rst_n     (rst_n),
      .connect_i (connect),
      .a_line_i  (a_line),
      .b_line_i  (b_line),
      .a_pull_o  (a_pull),
      .b_pull_o  (b_pull)
   );

   function automatic logic [1:0] exp_pulls();
      return {connect && (m_own == 2), connect && (m_own == 1)};
   endfunction

   function automatic string tag_now();
      if (!connect)        return "R5";
      else if (m_own == 1) return "R1/R3";
      else if (m_own == 2) return "R2/R3";
      else                 return "R4/R7";
   endfunction

   task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual={a,b}=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic model_step();
      logic fa, fb, a_blk, b_blk;
      if (!rst_n) begin
         m_own = 0; m_cnt = 0; m_blk = 0; m_pa = '1; m_pb = '1;
      end else begin
         fa = m_pa[S-1];
         fb = m_pb[S-1];
         a_blk = (m_cnt != 0) && (m_blk == 0);
         b_blk = (m_cnt != 0) && (m_blk == 1);
         if (!connect) begin
            m_own = 0; m_cnt = 0;
         end else begin
            case (m_own)
               0: begin
                  if (!fa && !a_blk)      m_own = 1;
                  else if (!fb && !b_blk) m_own = 2;
                  if (m_cnt != 0) m_cnt--;
               end
               1: if (fa) begin m_own = 0; m_cnt = SETTLE; m_blk = 1; end
                  else if (m_cnt != 0) m_cnt--;
               default: if (fb) begin m_own = 0; m_cnt = SETTLE; m_blk = 0; end
                  else if (m_cnt != 0) m_cnt--;
            endcase
         end
         m_pa = {m_pa[S-2:0], samp_a};
         m_pb = {m_pb[S-2:0], samp_b};
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk({a_pull, b_pull}, exp_pulls(), tag_now());
      n_chk++;
      if (a_pull && b_pull) begin
         n_err++;
         $display("FAIL R8 actual={a,b}=11 expected=not both high");
      end
      ext_a = nx_a; ext_b = nx_b; connect = nx_conn; rst_n = nx_rst;
      #1;
      samp_a = a_line; samp_b = b_line;
      @(posedge clk);
      #1;
      model_step();
   endtask

   task automatic idle(input int n);
      nx_a = 1'b0; nx_b = 1'b0; nx_conn = 1'b1;
      repeat (n) step();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      // R9: reset state
      repeat (3) step();
      chk({a_pull, b_pull}, 2'b00, "R9 in reset");
      nx_rst = 1'b1;
      step();
      chk({a_pull, b_pull}, 2'b00, "R9 after reset");
      idle(4);

      // R1 then R3 hold, then R4 release
      nx_a = 1'b1; step(); step(); step();
      chk({a_pull, b_pull}, 2'b01, "R1 A low drives B");
      nx_b = 1'b1; repeat (4) step();
      chk({a_pull, b_pull}, 2'b01, "R3 both low held");
      nx_b = 1'b0; repeat (4) step();
      chk({a_pull, b_pull}, 2'b01, "R3 driven side still held");
      nx_a = 1'b0; step(); step(); step();
      chk({a_pull, b_pull}, 2'b00, "R4 release after owner rises");
      idle(10);

      // R2
      nx_b = 1'b1; step(); step(); step();
      chk({a_pull, b_pull}, 2'b10, "R2 B low drives A");
      idle(12);

      // R7 stretch handover
      nx_a = 1'b1; step(); step(); step();
      nx_b = 1'b1; step(); step();
      nx_a = 1'b0; step(); step(); step();
      chk({a_pull, b_pull}, 2'b00, "R4 owner release during stretch");
      repeat (4) step();
      chk({a_pull, b_pull}, 2'b00, "R7 blocked during settle");
      step();
      chk({a_pull, b_pull}, 2'b10, "R7 stretch claims after settle");
      idle(14);

      // R6 tie
      nx_a = 1'b1; nx_b = 1'b1; step(); step(); step();
      chk({a_pull, b_pull}, 2'b01, "R6 tie resolves to A");
      idle(14);

      // R5 disconnect and reconnect
      nx_a = 1'b1; step(); step(); step();
      nx_conn = 1'b0; step();
      chk({a_pull, b_pull}, 2'b00, "R5 disconnect isolates");
      step(); step();
      chk({a_pull, b_pull}, 2'b00, "R5 stays isolated");
      nx_conn = 1'b1; step();
      chk({a_pull, b_pull}, 2'b01, "R5 reconnect claims afresh");
      idle(12);

      // random wired-AND traffic
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 5) == 0) nx_a = ~nx_a;
         if ($urandom_range(0, 5) == 0) nx_b = ~nx_b;
         nx_conn = ($urandom_range(0, 49) != 0);
         step();
      end
      idle(12);
      chk({a_pull, b_pull}, 2'b00, "R4 idle after random traffic");
      finish_run();
   end

endmodule